// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This controller gathers interrupt requests from twenty-four sources and tells a host processor which one to serve next. Sources 0 to 3 come from chip pins and pass through a two-flop synchronizer. Each of these four can be set to edge or level capture. Sources 4 to 23 are on-chip, synchronous and level-sensitive. Every source has its own enable bit and a three-bit priority, so there are eight levels. A priority stack lets a more urgent request nest over one already in service.

The host reads the vector register to acknowledge the request that is presented. The read returns the source number and its level and pushes that level onto the stack. A write to the end-of-interrupt register pops the stack. A separate fast request input has its own enable bit and its own output. That output does not go through arbitration or the stack. All configuration uses a plain register bus with read and write strobes. There is no data stream at the edge, so no pin uses a valid/ready handshake.

Register map (word address on `bus_addr`):
- 0: source enable, bit n for source n (1 = enabled).
- 1 to 3: priorities. Each holds eight 4-bit nibbles; nibble j of address 1+w is source 8w+j. Only the low three bits of a nibble are stored.
- 4: capture mode for sources 0 to 3, bit n (1 = edge, 0 = level).
- 5: vector, read only. Bit 31 = valid, bits 10:8 = level, bits 4:0 = source.
- 6: end-of-interrupt, write only.
- 7: pending bits, read only.
- 8: fast request enable, bit 0.

Top module: `pvic_top`

## Requirements
- R1: After reset all enables, modes and priorities are zero, and `irq` and `fast_irq` are low. A vector read returns 0.
- R2: Among pending enabled sources, the one with the highest priority is presented.
- R3: When pending enabled sources share the highest priority, the lowest source number is presented.
- R4: A source whose enable bit is 0 never raises `irq` and is never presented.
- R5: When `irq` is high, a vector read returns bit 31 = 1, the level in bits 10:8 and the source in bits 4:0. With `irq` low the read returns 0 and has no side effect.
- R6: A vector read with `irq` high pushes the presented level. After that, `irq` rises only for a request whose priority is strictly above the stack top.
- R7: A write to address 6 pops one stack level, and a pending request above the new top becomes presentable again.
- R8: A source 0 to 3 in edge mode latches a rising input as pending until its vector is read. The acknowledge clears it.
- R9: A source 0 to 3 in level mode is pending only while its input is high.
- R10: `fast_irq` is high exactly when the fast enable bit is 1 and the synchronized `fast_req` is high, whatever the stack and the other sources are doing.
- R11: The enable and priority registers read back what was written, with each priority nibble cut to its low three bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_req | input | 24 | Raw requests; bits 3:0 from pins, 23:4 on-chip |
| fast_req | input | 1 | Fast request from a pin |
| bus_rd | input | 1 | Register read strobe |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from state |
| irq | output | 1 | Normal interrupt request to the host |
| fast_irq | output | 1 | Fast interrupt request to the host |

## Verification
A wrong stack top shows up in two ways. An equal-priority request raises `irq` again in the cycle after an acknowledge, or `irq` stays low after an end-of-interrupt although a higher request is waiting. Either way it is visible one cycle after the bus access. A pending bit that sticks or clears at the wrong time gives a repeated or missing vector and a wrong pending-register read. An arbitration fault returns the wrong source number on the first vector read after the requests settle.

// File: rtl/pvic_pkg.sv
package pvic_pkg;
  localparam int ADDR_W = 4;
  localparam int DATA_W = 32;
  localparam logic [ADDR_W-1:0] A_ENABLE = 4'd0;
  localparam logic [ADDR_W-1:0] A_PRIO0  = 4'd1;
  localparam logic [ADDR_W-1:0] A_MODE   = 4'd4;
  localparam logic [ADDR_W-1:0] A_VECTOR = 4'd5;
  localparam logic [ADDR_W-1:0] A_EOI    = 4'd6;
  localparam logic [ADDR_W-1:0] A_PEND   = 4'd7;
  localparam logic [ADDR_W-1:0] A_FAST   = 4'd8;
  localparam int NIB_PER_WORD = 8;
endpackage

// File: rtl/pvic_sync.sv
module pvic_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q, hold_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      meta_q <= '0;
      hold_q <= '0;
    end else begin
      meta_q <= d;
      hold_q <= meta_q;
    end
  end

  assign q = hold_q;
endmodule

// File: rtl/pvic_arb.sv
module pvic_arb #(
  parameter int NSRC = 24,
  parameter int LW   = 3,
  parameter int IW   = 5
) (
  input  logic [NSRC-1:0]    active,
  input  logic [NSRC*LW-1:0] prio_flat,
  output logic               hit,
  output logic [IW-1:0]      win_id,
  output logic [LW-1:0]      win_lvl
);
  always_comb begin
    hit     = 1'b0;
    win_id  = '0;
    win_lvl = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (active[i] && (!hit || prio_flat[i*LW +: LW] > win_lvl)) begin
        hit     = 1'b1;
        win_id  = IW'(i);
        win_lvl = prio_flat[i*LW +: LW];
      end
    end
  end
endmodule

// File: rtl/pvic_stack.sv
module pvic_stack #(
  parameter int DEPTH = 8,
  parameter int LW    = 3,
  localparam int DW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [LW-1:0] push_lvl,
  input  logic          pop,
  output logic [DW-1:0] depth,
  output logic [LW-1:0] top_lvl
);
  logic [LW-1:0] lvl_q [DEPTH];
  logic [DW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      for (int i = 0; i < DEPTH; i++) lvl_q[i] <= '0;
    end else if (push && cnt_q != DW'(DEPTH)) begin
      for (int i = 0; i < DEPTH; i++)
        if (DW'(i) == cnt_q) lvl_q[i] <= push_lvl;
      cnt_q <= cnt_q + 1'b1;
    end else if (pop && cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  always_comb begin
    top_lvl = '0;
    for (int i = 0; i < DEPTH; i++)
      if (DW'(i + 1) == cnt_q) top_lvl = lvl_q[i];
  end

  assign depth = cnt_q;
endmodule

// File: rtl/pvic_top.sv
module pvic_top
  import pvic_pkg::*;
#(
  parameter int NSRC = 24,
  parameter int NEXT = 4,
  parameter int NLVL = 8,
  localparam int LW  = $clog2(NLVL),
  localparam int IW  = $clog2(NSRC),
  localparam int DW  = $clog2(NLVL + 1),
  localparam int PW  = (NSRC + NIB_PER_WORD - 1) / NIB_PER_WORD
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   src_req,
  input  logic              fast_req,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq,
  output logic              fast_irq
);
  logic [NSRC-1:0]    en_q, pend_q, raw, active;
  logic [NEXT-1:0]    mode_q, prev_q;
  logic [NEXT:0]      pin_s;
  logic               fast_en_q;
  logic [LW-1:0]      prio_q [NSRC];
  logic [NSRC*LW-1:0] prio_flat;
  logic               hit, ack_w, eoi_w;
  logic [IW-1:0]      win_id;
  logic [LW-1:0]      win_lvl, top_lvl;
  logic [DW-1:0]      depth;
  logic               unused_bits;

  pvic_sync #(.W(NEXT + 1)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({fast_req, src_req[NEXT-1:0]}), .q(pin_s)
  );

  assign raw = {src_req[NSRC-1:NEXT], pin_s[NEXT-1:0]};
  assign fast_irq = fast_en_q & pin_s[NEXT];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q      <= '0;
      mode_q    <= '0;
      fast_en_q <= 1'b0;
    end else if (bus_wr) begin
      if (bus_addr == A_ENABLE) en_q <= bus_wdata[NSRC-1:0];
      if (bus_addr == A_MODE)   mode_q <= bus_wdata[NEXT-1:0];
      if (bus_addr == A_FAST)   fast_en_q <= bus_wdata[0];
    end
  end

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    localparam logic [ADDR_W-1:0] PADDR = A_PRIO0 + ADDR_W'(i / NIB_PER_WORD);
    localparam int NIB = (i % NIB_PER_WORD) * 4;

    always_ff @(posedge clk) begin
      if (!rst_n) prio_q[i] <= '0;
      else if (bus_wr && bus_addr == PADDR) prio_q[i] <= bus_wdata[NIB +: LW];
    end
    assign prio_flat[i*LW +: LW] = prio_q[i];

    if (i < NEXT) begin : g_pin
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          pend_q[i] <= 1'b0;
          prev_q[i] <= 1'b0;
        end else begin
          prev_q[i] <= raw[i];
          if (!mode_q[i])                  pend_q[i] <= raw[i];
          else if (raw[i] && !prev_q[i])   pend_q[i] <= 1'b1;
          else if (ack_w && win_id == IW'(i)) pend_q[i] <= 1'b0;
        end
      end
    end else begin : g_int
      always_ff @(posedge clk) begin
        if (!rst_n) pend_q[i] <= 1'b0;
        else        pend_q[i] <= raw[i];
      end
    end
  end

  assign active = pend_q & en_q;

  pvic_arb #(.NSRC(NSRC), .LW(LW), .IW(IW)) u_arb (
    .active(active), .prio_flat(prio_flat),
    .hit(hit), .win_id(win_id), .win_lvl(win_lvl)
  );

  assign irq   = hit && (depth == '0 || win_lvl > top_lvl);
  assign ack_w = bus_rd && bus_addr == A_VECTOR && irq;
  assign eoi_w = bus_wr && bus_addr == A_EOI;

  pvic_stack #(.DEPTH(NLVL), .LW(LW)) u_stack (
    .clk(clk), .rst_n(rst_n), .push(ack_w), .push_lvl(win_lvl),
    .pop(eoi_w), .depth(depth), .top_lvl(top_lvl)
  );

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == A_ENABLE) bus_rdata[NSRC-1:0] = en_q;
    if (bus_addr == A_MODE)   bus_rdata[NEXT-1:0] = mode_q;
    if (bus_addr == A_FAST)   bus_rdata[0] = fast_en_q;
    if (bus_addr == A_PEND)   bus_rdata[NSRC-1:0] = pend_q;
    if (bus_addr == A_VECTOR && irq) begin
      bus_rdata[DATA_W-1] = 1'b1;
      bus_rdata[8 +: LW]  = win_lvl;
      bus_rdata[0 +: IW]  = win_id;
    end
    for (int w = 0; w < PW; w++)
      if (bus_addr == A_PRIO0 + ADDR_W'(w))
        for (int j = 0; j < NIB_PER_WORD; j++)
          if (w * NIB_PER_WORD + j < NSRC)
            bus_rdata[j*4 +: LW] = prio_q[w * NIB_PER_WORD + j];
  end

  assign unused_bits = ^bus_wdata;
endmodule

// File: rtl/pvic_chk.sv
module pvic_chk #(
  parameter int NSRC = 24,
  parameter int NLVL = 8,
  parameter int DW   = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            irq,
  input logic            fast_irq,
  input logic            fast_en,
  input logic [NSRC-1:0] en_mask,
  input logic [DW-1:0]   depth,
  input logic            ack,
  input logic            eoi
);
  AST_FAST_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !fast_en |-> !fast_irq); // R10
  AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (en_mask == '0) |-> !irq); // R4
  AST_STACK_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    depth <= DW'(NLVL)); // R6
  AST_ACK_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> depth == $past(depth) + 1'b1); // R6
  AST_EOI_POP: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi && depth != '0) |=> depth == $past(depth) - 1'b1); // R7
endmodule

bind pvic_top pvic_chk #(.NSRC(NSRC), .NLVL(NLVL), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .irq(irq), .fast_irq(fast_irq),
  .fast_en(fast_en_q), .en_mask(en_q), .depth(depth),
  .ack(ack_w), .eoi(eoi_w)
);

// File: tb/pvic_top_test.sv
module pvic_top_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [23:0] src_req = '0;
  logic        fast_req = 1'b0;
  logic        bus_rd = 1'b0, bus_wr = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq, fast_irq;
  int checks = 0, errors = 0;
  logic [31:0] exp_q [$];
  string       tag_q [$];

  always #4 clk = ~clk;

  pvic_top uut (
    .clk(clk), .rst_n(rst_n), .src_req(src_req), .fast_req(fast_req),
    .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq), .fast_irq(fast_irq)
  );

  // monitor: pops the scoreboard when a read is on the bus
  always begin
    @(negedge clk);
    #2;
    if (bus_rd && exp_q.size() > 0) begin
      logic [31:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (bus_rdata !== e) begin
        errors++;
        $display("FAIL %s read got %h expected %h", t, bus_rdata, e);
      end
    end
  end

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [31:0] e, input string t);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic pin(input logic got, input logic e, input string t);
    #2;
    checks++;
    if (got !== e) begin
      errors++;
      $display("FAIL %s pin got %b expected %b", t, got, e);
    end
  endtask

  initial begin
    #(200000 * 8);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    settle(3);
    rst_n = 1'b1;
    settle(1);
    pin(irq, 1'b0, "R1 irq");
    pin(fast_irq, 1'b0, "R1 fast_irq");
    rd(4'd0, 32'h0, "R1 enable");
    rd(4'd5, 32'h0, "R1 R5 vector");

    // priorities: src4=2, src5=5, src6=5, src7=1; src8 written 0xF
    wr(4'd1, 32'h1552_0000);
    rd(4'd1, 32'h1552_0000, "R11 prio word0");
    wr(4'd2, 32'h0000_000F);
    rd(4'd2, 32'h0000_0007, "R11 prio nibble clipped");

    src_req[4] = 1'b1;
    settle(3);
    pin(irq, 1'b0, "R4 masked");
    rd(4'd5, 32'h0, "R4 R5 no vector");

    src_req[7:5] = 3'b111;
    wr(4'd0, 32'h0000_00F0);
    rd(4'd0, 32'h0000_00F0, "R11 enable");
    settle(2);
    pin(irq, 1'b1, "R2 raised");
    rd(4'd5, 32'h8000_0505, "R2 R3 R5 tie to src5");
    pin(irq, 1'b0, "R6 equal level blocked");

    src_req[8] = 1'b1;
    wr(4'd0, 32'h0000_01F0);
    settle(2);
    pin(irq, 1'b1, "R6 nested higher");
    rd(4'd5, 32'h8000_0708, "R6 nested vector");
    pin(irq, 1'b0, "R6 after nest");

    src_req[8] = 1'b0; src_req[5] = 1'b0;
    settle(2);
    wr(4'd6, 32'h0);
    pin(irq, 1'b0, "R7 top still 5");
    wr(4'd6, 32'h0);
    pin(irq, 1'b1, "R7 reopened");
    rd(4'd5, 32'h8000_0506, "R7 src6 served");
    src_req[6] = 1'b0;
    settle(2);
    wr(4'd6, 32'h0);
    rd(4'd5, 32'h8000_0204, "R2 src4 over src7");
    pin(irq, 1'b0, "R6 lower blocked");
    wr(4'd6, 32'h0);
    src_req[4] = 1'b0; src_req[7] = 1'b0;
    settle(2);
    pin(irq, 1'b0, "R9 internal dropped");

    // external source 0, edge mode, priority 3
    wr(4'd1, 32'h1552_0003);
    wr(4'd0, 32'h0000_01F1);
    wr(4'd4, 32'h0000_0001);
    @(negedge clk); src_req[0] = 1'b1;
    @(negedge clk); src_req[0] = 1'b0;
    settle(5);
    pin(irq, 1'b1, "R8 pulse latched");
    rd(4'd7, 32'h0000_0001, "R8 pending bit");
    rd(4'd5, 32'h8000_0300, "R8 vector src0");
    wr(4'd6, 32'h0);
    settle(2);
    pin(irq, 1'b0, "R8 cleared by ack");
    rd(4'd7, 32'h0, "R8 pending cleared");

    // level mode on source 0
    wr(4'd4, 32'h0);
    src_req[0] = 1'b1;
    settle(4);
    pin(irq, 1'b1, "R9 level high");
    src_req[0] = 1'b0;
    settle(4);
    pin(irq, 1'b0, "R9 level low");

    // fast path
    fast_req = 1'b1;
    settle(4);
    pin(fast_irq, 1'b0, "R10 fast disabled");
    wr(4'd8, 32'h1);
    pin(fast_irq, 1'b1, "R10 fast enabled");
    pin(irq, 1'b0, "R10 normal path idle");
    fast_req = 1'b0;
    settle(4);
    pin(fast_irq, 1'b0, "R10 fast released");

    settle(2);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule